// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block adds or subtracts two integer operands and produces the truncated result together with six status flags: carry, signed overflow, sign, zero, half-carry and even parity. A two-bit size code picks an 8-bit, 16-bit or full-width (32-bit by default) operation. Operand bits above the chosen size are ignored. The carry, overflow and sign positions move to the top bit of that size.

The result and the status flags go into a register that loads only in a cycle where the valid strobe is high. The same register also holds a direction control bit. Arithmetic never touches the direction bit. It changes only through its own set and clear inputs. An execution unit can use the registered flag vector as its condition state.

Top module: `arithFlagUnit`

## Requirements
- R1: In a cycle with `valid` high, the registered `result` becomes A+B when `isSub`=0, or A−B when `isSub`=1. Subtraction is done as A plus the two's complement of B. The result is truncated to the selected size, and the bits above that size read 0. It appears one clock after the strobe.
- R2: Carry (flags bit 0) is the carry out of the top bit of the selected size on an add. On a subtract it is a borrow, set exactly when A < B as unsigned numbers of that size.
- R3: Overflow (flags bit 1) is set when the true signed two's complement sum or difference of the size-truncated operands falls outside the signed range of that size.
- R4: Sign (flags bit 2) equals the most significant bit of the result within the selected size.
- R5: Zero (flags bit 3) is set when every result bit within the selected size is 0.
- R6: Half-carry (flags bit 4) is set on an add when bit 3 carries into bit 4. On a subtract it is set when the low nibble borrows, meaning A[3:0] < B[3:0].
- R7: Parity (flags bit 5) is set when the low byte of the result holds an even number of 1 bits.
- R8: Size code 2'b00 selects 8 bits, 2'b01 selects 16 bits, and both 2'b10 and 2'b11 select the full width. Operand bits above the selected size have no effect on the result or on any flag.
- R9: In a cycle with `valid` low, `result` and flags bits 5..0 keep their values whatever the other inputs do.
- R10: Direction (flags bit 6) is set by `setDir` and cleared by `clrDir`. When both are high, set wins. The bit holds when neither is high, and no arithmetic operation changes it.
- R11: Synchronous active-high `rst` clears `result` and all seven flag bits to 0 at the next clock edge.
- R12: The flag vector is laid out from bit 0 upward as carry, overflow, sign, zero, half-carry, parity, direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Load the result and status flags this cycle |
| isSub | input | 1 | 0 = add, 1 = subtract |
| sizeSel | input | 2 | Operand size code (00: 8, 01: 16, 1x: full width) |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand |
| setDir | input | 1 | Set the direction bit |
| clrDir | input | 1 | Clear the direction bit |
| result | output | DATA_W | Registered truncated result |
| flags | output | 7 | Registered flags: {dir, parity, half-carry, zero, sign, overflow, carry} |

## Verification
The bench builds the block with its default DATA_W of 32. This makes the byte size small enough for a near-exhaustive sweep: every A value against every fifth B value, in both add and subtract, with random junk driven into the operand bits above bit 7. The 16-bit and full-width sizes get a cross product of boundary values (0, 1, the largest positive number, the most negative number, all ones) plus several thousand pseudo-random pairs. Together these cover every carry, borrow and overflow corner. All expected values come from plain integer arithmetic in the bench. Separate sequences check the hold-on-idle behaviour, the direction set/clear priority, the flag-vector layout and reset.

// File: rtl/flagPkg.sv
package flagPkg;

  localparam int NUM_SIZES = 3;

  typedef struct packed {
    logic dir;
    logic parity;
    logic aux;
    logic zero;
    logic sign;
    logic ovf;
    logic carry;
  } flagsT;

  typedef struct packed {
    logic loadArith;
    logic dirSet;
    logic dirClr;
  } strobeT;

endpackage

// File: rtl/flagCtrl.sv
module flagCtrl
  import flagPkg::*;
(
  input  logic   valid,
  input  logic   setDir,
  input  logic   clrDir,
  output strobeT strobe
);

  // Set has priority over clear for the direction bit.
  always_comb begin
    strobe.loadArith = valid;
    strobe.dirSet    = setDir;
    strobe.dirClr    = clrDir & ~setDir;
  end

endmodule

// File: rtl/flagDatapath.sv
module flagDatapath
  import flagPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobe,
  input  logic              isSub,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resultQ,
  output flagsT             flagsQ
);

  localparam int EXT_W = DATA_W + 1;
  localparam int IDX_W = $clog2(NUM_SIZES);

  logic [DATA_W-1:0] bEff;
  logic [EXT_W-1:0]  sumX;
  logic [EXT_W-1:0]  carryVec;
  logic [IDX_W-1:0]  sizeIdx;

  logic [NUM_SIZES-1:0] cyBySize;
  logic [NUM_SIZES-1:0] ovBySize;
  logic [NUM_SIZES-1:0] sgBySize;
  logic [NUM_SIZES-1:0] zrBySize;
  logic [DATA_W-1:0]    resBySize [NUM_SIZES];

  // Subtract as A + ~B + 1.
  assign bEff     = isSub ? ~opB : opB;
  assign sumX     = {1'b0, opA} + {1'b0, bEff} + EXT_W'(isSub);
  // Carry into each bit position (top bit is the final carry out).
  assign carryVec = sumX ^ {1'b0, opA} ^ {1'b0, bEff};

  always_comb begin
    case (sizeSel)
      2'b00:   sizeIdx = IDX_W'(0);
      2'b01:   sizeIdx = IDX_W'(1);
      default: sizeIdx = IDX_W'(NUM_SIZES - 1);
    endcase
  end

  generate
    for (genvar g = 0; g < NUM_SIZES; g++) begin : gSize
      localparam int W = (g == NUM_SIZES - 1) ? DATA_W : (8 << g);
      localparam logic [DATA_W-1:0] MASK = {DATA_W{1'b1}} >> (DATA_W - W);
      assign resBySize[g] = sumX[DATA_W-1:0] & MASK;
      assign cyBySize[g]  = carryVec[W] ^ isSub;
      assign ovBySize[g]  = carryVec[W] ^ carryVec[W-1];
      assign sgBySize[g]  = sumX[W-1];
      assign zrBySize[g]  = ~|sumX[W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ <= '0;
      flagsQ  <= '0;
    end else begin
      if (strobe.loadArith) begin
        resultQ       <= resBySize[sizeIdx];
        flagsQ.carry  <= cyBySize[sizeIdx];
        flagsQ.ovf    <= ovBySize[sizeIdx];
        flagsQ.sign   <= sgBySize[sizeIdx];
        flagsQ.zero   <= zrBySize[sizeIdx];
        flagsQ.aux    <= carryVec[4] ^ isSub;
        flagsQ.parity <= ~^sumX[7:0];
      end
      if (strobe.dirSet)      flagsQ.dir <= 1'b1;
      else if (strobe.dirClr) flagsQ.dir <= 1'b0;
    end
  end

  // R11
  reset_clear_chk: assert property (@(posedge clk) rst |=> (resultQ == '0 && flagsQ == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadArith |=> ($stable(resultQ) && $stable(flagsQ[5:0])));

  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.dirSet && !strobe.dirClr) |=> $stable(flagsQ.dir));

  // R10
  dir_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.dirSet, strobe.dirClr}));

  // R2
  borrow_word_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadArith && isSub && sizeSel[1]) |=> (flagsQ.carry == ($past(opA) < $past(opB))));

  // R7
  parity_byte_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.loadArith |=> (flagsQ.parity == ~^resultQ[7:0]));

endmodule

// File: rtl/arithFlagUnit.sv
module arithFlagUnit
  import flagPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              isSub,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              setDir,
  input  logic              clrDir,
  output logic [DATA_W-1:0] result,
  output logic [6:0]        flags
);

  strobeT strobe;
  flagsT  flagsQ;

  flagCtrl u_ctrl (
    .valid  (valid),
    .setDir (setDir),
    .clrDir (clrDir),
    .strobe (strobe)
  );

  flagDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .isSub   (isSub),
    .sizeSel (sizeSel),
    .opA     (opA),
    .opB     (opB),
    .resultQ (result),
    .flagsQ  (flagsQ)
  );

  assign flags = flagsQ;

endmodule

// File: tb/arithFlagUnit_tb.sv
`timescale 1ns/1ps
module arithFlagUnit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic        isSub = 1'b0;
  logic [1:0]  sizeSel = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        setDir = 1'b0;
  logic        clrDir = 1'b0;
  logic [31:0] result;
  logic [6:0]  flags;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  arithFlagUnit #(.DATA_W(32)) u_dut (
    .clk(clk), .rst(rst), .valid(valid), .isSub(isSub), .sizeSel(sizeSel),
    .opA(opA), .opB(opB), .setDir(setDir), .clrDir(clrDir),
    .result(result), .flags(flags)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (A=%h B=%h sub=%0d size=%0d)",
               tag, got, exp, opA, opB, isSub, sizeSel);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Expected values from plain integer arithmetic.
  task automatic refOp(input logic [31:0] a, input logic [31:0] b, input bit sub,
                       input logic [1:0] sz, output logic [31:0] res, output logic [5:0] f);
    int w;
    longint mask, ua, ub, full, sa, sb, sr, half;
    w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    mask = (64'sd1 <<< w) - 1;
    half = 64'sd1 <<< (w - 1);
    ua = longint'(a) & mask;
    ub = longint'(b) & mask;
    full = sub ? (ua - ub) : (ua + ub);
    res = 32'(full & mask);
    sa = (ua >= half) ? ua - (64'sd1 <<< w) : ua;
    sb = (ub >= half) ? ub - (64'sd1 <<< w) : ub;
    sr = sub ? (sa - sb) : (sa + sb);
    f[0] = sub ? (ua < ub) : ((full >>> w) != 0);
    f[1] = (sr > half - 1) || (sr < -half);
    f[2] = ((longint'(res) >>> (w - 1)) & 1) != 0;
    f[3] = (res == 0);
    f[4] = sub ? ((ua & 15) < (ub & 15)) : (((ua & 15) + (ub & 15)) > 15);
    f[5] = ($countones(res[7:0]) % 2) == 0;
  endtask

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input bit sub,
                       input logic [1:0] sz);
    logic [31:0] eRes;
    logic [5:0]  eF;
    @(negedge clk);
    opA = a; opB = b; isSub = sub; sizeSel = sz; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    refOp(a, b, sub, sz, eRes, eF);
    chk("R1/R8 result", result, eRes);
    chk("R2 carry", 32'(flags[0]), 32'(eF[0]));
    chk("R3 overflow", 32'(flags[1]), 32'(eF[1]));
    chk("R4 sign", 32'(flags[2]), 32'(eF[2]));
    chk("R5 zero", 32'(flags[3]), 32'(eF[3]));
    chk("R6 halfcarry", 32'(flags[4]), 32'(eF[4]));
    chk("R7 parity", 32'(flags[5]), 32'(eF[5]));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] edgeV [5];
    logic [6:0]  held;
    logic [31:0] heldRes;

    // R11: reset state
    repeat (2) @(negedge clk);
    chk("R11 reset result", result, 32'h0);
    chk("R11 reset flags", 32'(flags), 32'h0);
    rst = 1'b0;

    // R12: layout, 8-bit 0x80 + 0x80 -> carry, ovf, zero, parity
    runOp(32'h0000_0080, 32'h0000_0080, 1'b0, 2'b00);
    chk("R12 layout", 32'(flags), 32'b0101011);

    // R8 / R1..R7: near-exhaustive byte sweep with junk in the upper bits
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        for (int s = 0; s < 2; s++) begin
          runOp({rnd()[31:8], 8'(a)}, {rnd()[31:8], 8'(b)}, s[0], 2'b00);
        end
      end
    end

    // Boundary cross products for 16-bit and full width
    for (int z = 1; z < 4; z++) begin
      int w;
      w = (z == 1) ? 16 : 32;
      edgeV[0] = 32'h0;
      edgeV[1] = 32'h1;
      edgeV[2] = (w == 16) ? 32'h7FFF : 32'h7FFF_FFFF;
      edgeV[3] = (w == 16) ? 32'h8000 : 32'h8000_0000;
      edgeV[4] = (w == 16) ? 32'hFFFF : 32'hFFFF_FFFF;
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int s = 0; s < 2; s++)
            runOp(edgeV[i] | ((w == 16) ? (rnd() & 32'hFFFF_0000) : 32'h0),
                  edgeV[j], s[0], 2'(z));
    end

    // Random operands at 16 bits and both full-width codes
    for (int k = 0; k < 2000; k++) runOp(rnd(), rnd(), k[0], 2'b01);
    for (int k = 0; k < 2000; k++) runOp(rnd(), rnd(), k[0], 2'b10);
    for (int k = 0; k < 500; k++)  runOp(rnd(), rnd(), k[0], 2'b11);

    // R9: idle cycles hold the result and status flags
    runOp(32'h0000_00FF, 32'h0000_0001, 1'b0, 2'b00);
    held = flags; heldRes = result;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opA = rnd(); opB = rnd(); isSub = k[0]; sizeSel = 2'(k);
    end
    @(negedge clk);
    chk("R9 hold result", result, heldRes);
    chk("R9 hold flags", 32'(flags[5:0]), 32'(held[5:0]));

    // R10: direction control
    @(negedge clk); setDir = 1'b1;
    @(negedge clk); setDir = 1'b0;
    chk("R10 set", 32'(flags[6]), 32'h1);
    runOp(32'h5, 32'h5, 1'b1, 2'b10);
    chk("R10 arith keeps dir", 32'(flags[6]), 32'h1);
    @(negedge clk); clrDir = 1'b1;
    @(negedge clk); clrDir = 1'b0;
    chk("R10 clear", 32'(flags[6]), 32'h0);
    runOp(32'hFFFF_FFFF, 32'h1, 1'b0, 2'b10);
    chk("R10 arith keeps clear", 32'(flags[6]), 32'h0);
    @(negedge clk); setDir = 1'b1; clrDir = 1'b1;
    @(negedge clk); setDir = 1'b0; clrDir = 1'b0;
    chk("R10 set wins", 32'(flags[6]), 32'h1);
    @(negedge clk);
    chk("R10 idle holds", 32'(flags[6]), 32'h1);

    // R11: reset mid-run
    runOp(32'h0000_0001, 32'h0000_0002, 1'b1, 2'b00);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R11 rerun result", result, 32'h0);
    chk("R11 rerun flags", 32'(flags), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule